// File: doc/BRIEF.md
# Feature Header Chain Walker

This block discovers the features that sit in a memory-mapped region by following a chain of 64-bit headers. After a start pulse it reads the header at a given base address over a simple one-at-a-time read port. It unpacks the header and files the feature's kind, identifier, revision and byte position into a small result table. It then moves to the next header. Each header carries its own distance to the next one, so the chain can be laid out anywhere in the region. For the two header kinds that carry a 128-bit unique identifier, the walker also reads the two words that follow the header and stores them next to the entry.

The walk ends normally on a header whose end-of-list flag is set. In that case the distance field holds the size of that last feature and is never followed. The walk also ends with an error code in three cases: a hop whose distance is not a multiple of eight bytes, a zero distance without the end flag (which would otherwise loop forever), and a header that arrives when every table slot is already filled. Software, or a sequencer, reads the table through an index port once `done` is high.

Top module: `fcw_walker`

## Requirements
- R1: After reset, `busy`, `done` and `rd_req` are 0, `err_code` is 0 and `tbl_count` is 0.
- R2: Header words are little-endian 64-bit values with these fields: kind in bits 63:60, end flag in bit 40, next distance in bits 39:16, revision in bits 15:12 and feature ID in bits 11:0. Each stored entry holds the kind, ID and revision, plus the header address minus the base address.
- R3: `rd_req` is high for exactly one cycle per read, and no new read is issued until `rd_valid` has answered the previous one.
- R4: The first read goes to the base address. Each later header is read at the previous header's address plus its next distance in bytes.
- R5: For kind 4'h1 (accelerator) and kind 4'h4 (management), the walker reads the low identifier word at header+8 and then the high word at header+16. `tbl_guid` holds {high, low}. For any other kind, no extra reads are made and `tbl_guid` reads 0.
- R6: A header with the end flag set finishes the walk with `err_code` 0 and issues no further read, whatever its distance field holds, even a misaligned one.
- R7: A header without the end flag whose distance has any of bits 2:0 set finishes the walk with `err_code` 1. The header itself is still stored.
- R8: A header without the end flag whose distance is 0 finishes the walk with `err_code` 2. The header itself is still stored.
- R9: A header that arrives when DEPTH entries are already stored finishes the walk with `err_code` 3 and is not stored. A chain of exactly DEPTH headers that ends with the end flag finishes with code 0.
- R10: `busy` rises in the cycle after an accepted start. `busy` and `done` are never high together. `done` stays high until the next start. `err_code` reads 0 while busy.
- R11: A start pulse while `busy` is high is ignored: the walk in progress, its reads and its results are unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Begin a walk from `base_addr` (single-cycle pulse) |
| base_addr | input | ADDR_W | Byte address of the first header |
| rd_req | output | 1 | Read request strobe |
| rd_addr | output | ADDR_W | Byte address of the requested 64-bit word |
| rd_valid | input | 1 | Read data valid |
| rd_data | input | 64 | Read data, little-endian word |
| busy | output | 1 | Walk in progress |
| done | output | 1 | Walk finished, results valid |
| err_code | output | 2 | 0 none, 1 misaligned, 2 zero loop, 3 table overflow |
| tbl_count | output | CW | Number of entries stored |
| tbl_idx | input | AW | Result table read index |
| tbl_kind | output | 4 | Kind of the indexed entry |
| tbl_fid | output | 12 | Feature ID of the indexed entry |
| tbl_rev | output | 4 | Revision of the indexed entry |
| tbl_offset | output | ADDR_W | Header address minus base for the indexed entry |
| tbl_guid | output | 128 | Identifier of the indexed entry, 0 if none |

## Verification
The assertions assume that the read port answers each request exactly once, with a single-cycle `rd_valid` that comes at least one cycle after the request and never while no read is pending. They also assume that `start` is a single-cycle pulse. The bench's memory responder replies to every request after a latency of one to three cycles, chosen in rotation, and never answers spontaneously. The only start pulse raised during a walk is the deliberate one used to show that it is ignored.

// File: rtl/fcw_pkg.sv
package fcw_pkg;

  typedef enum logic [1:0] {
    WERR_NONE     = 2'd0,
    WERR_MISALIGN = 2'd1,
    WERR_ZLOOP    = 2'd2,
    WERR_OVERFLOW = 2'd3
  } walk_err_e;

  localparam logic [3:0] KIND_ACCEL = 4'h1;
  localparam logic [3:0] KIND_MGMT  = 4'h4;

  typedef struct packed {
    logic [3:0]  kind;
    logic        last;
    logic [23:0] nxt;
    logic [3:0]  rev;
    logic [11:0] fid;
  } hdr_t;

  function automatic hdr_t hdr_unpack(input logic [63:0] w);
    hdr_t h;
    h.kind = w[63:60];
    h.last = w[40];
    h.nxt  = w[39:16];
    h.rev  = w[15:12];
    h.fid  = w[11:0];
    return h;
  endfunction

  function automatic logic wants_guid(input logic [3:0] k);
    return (k == KIND_ACCEL) || (k == KIND_MGMT);
  endfunction

  // Error raised by a hop that is not the final one.
  function automatic walk_err_e hop_check(input logic [23:0] nxt);
    if (nxt[2:0] != 3'd0) return WERR_MISALIGN;
    if (nxt == 24'd0)     return WERR_ZLOOP;
    return WERR_NONE;
  endfunction

endpackage

// File: rtl/fcw_hdr_decode.sv
module fcw_hdr_decode
  import fcw_pkg::*;
(
  input  logic [63:0] word,
  output hdr_t        fields,
  output logic        guid_need
);
  assign fields    = hdr_unpack(word);
  assign guid_need = wants_guid(fields.kind);
endmodule

// File: rtl/fcw_table.sv
module fcw_table #(
  parameter int DEPTH  = 8,
  parameter int ADDR_W = 32,
  parameter int AW     = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              hdr_we,
  input  logic [AW-1:0]     hdr_idx,
  input  logic [3:0]        hdr_kind,
  input  logic [11:0]       hdr_fid,
  input  logic [3:0]        hdr_rev,
  input  logic [ADDR_W-1:0] hdr_off,
  input  logic              glo_we,
  input  logic              ghi_we,
  input  logic [AW-1:0]     g_idx,
  input  logic [63:0]       g_data,
  input  logic [AW-1:0]     rd_idx,
  output logic [3:0]        rd_kind,
  output logic [11:0]       rd_fid,
  output logic [3:0]        rd_rev,
  output logic [ADDR_W-1:0] rd_off,
  output logic [127:0]      rd_guid
);
  logic [3:0]        kind_a [DEPTH];
  logic [11:0]       fid_a  [DEPTH];
  logic [3:0]        rev_a  [DEPTH];
  logic [ADDR_W-1:0] off_a  [DEPTH];
  logic [63:0]       glo_a  [DEPTH];
  logic [63:0]       ghi_a  [DEPTH];

  for (genvar i = 0; i < DEPTH; i++) begin : g_ent
    logic [3:0]        kind_r;
    logic [11:0]       fid_r;
    logic [3:0]        rev_r;
    logic [ADDR_W-1:0] off_r;
    logic [63:0]       glo_r;
    logic [63:0]       ghi_r;
    wire sel_h = hdr_we && (hdr_idx == AW'(i));
    wire sel_l = glo_we && (g_idx == AW'(i));
    wire sel_u = ghi_we && (g_idx == AW'(i));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        kind_r <= '0;
        fid_r  <= '0;
        rev_r  <= '0;
        off_r  <= '0;
        glo_r  <= '0;
        ghi_r  <= '0;
      end else begin
        if (sel_h) begin
          kind_r <= hdr_kind;
          fid_r  <= hdr_fid;
          rev_r  <= hdr_rev;
          off_r  <= hdr_off;
          glo_r  <= '0;
          ghi_r  <= '0;
        end
        if (sel_l) glo_r <= g_data;
        if (sel_u) ghi_r <= g_data;
      end
    end

    assign kind_a[i] = kind_r;
    assign fid_a[i]  = fid_r;
    assign rev_a[i]  = rev_r;
    assign off_a[i]  = off_r;
    assign glo_a[i]  = glo_r;
    assign ghi_a[i]  = ghi_r;
  end

  wire in_rng = (32'(rd_idx) < DEPTH);
  assign rd_kind = in_rng ? kind_a[rd_idx] : '0;
  assign rd_fid  = in_rng ? fid_a[rd_idx]  : '0;
  assign rd_rev  = in_rng ? rev_a[rd_idx]  : '0;
  assign rd_off  = in_rng ? off_a[rd_idx]  : '0;
  assign rd_guid = in_rng ? {ghi_a[rd_idx], glo_a[rd_idx]} : '0;
endmodule

// File: rtl/fcw_walk_ctrl.sv
module fcw_walk_ctrl
  import fcw_pkg::*;
#(
  parameter int DEPTH  = 8,
  parameter int ADDR_W = 32,
  parameter int AW     = 3,
  parameter int CW     = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [ADDR_W-1:0] base_addr,
  input  logic              rd_valid,
  input  logic              in_last,
  input  logic [23:0]       in_nxt,
  input  logic              guid_need,
  output logic              rd_req,
  output logic [ADDR_W-1:0] rd_addr,
  output logic              busy,
  output logic              done,
  output walk_err_e         err,
  output logic [CW-1:0]     cnt,
  output logic              hdr_we,
  output logic [AW-1:0]     hdr_idx,
  output logic [ADDR_W-1:0] hdr_off,
  output logic              glo_we,
  output logic              ghi_we,
  output logic [AW-1:0]     g_idx
);
  typedef enum logic [2:0] {
    S_IDLE, S_RQ_HDR, S_WT_HDR, S_RQ_GLO, S_WT_GLO, S_RQ_GHI, S_WT_GHI, S_HOP
  } st_e;

  st_e               st;
  logic [ADDR_W-1:0] cur_q, base_q;
  logic              last_q;
  logic [23:0]       nxt_q;
  logic [AW-1:0]     slot_q;

  // Named internal events.
  wire       tbl_full  = (cnt == CW'(DEPTH));
  wire       hdr_in    = (st == S_WT_HDR) && rd_valid;
  walk_err_e hop_err;
  assign     hop_err   = hop_check(nxt_q);
  wire       walk_stop = (st == S_HOP) && (last_q || hop_err != WERR_NONE);

  always_comb begin
    rd_req  = (st == S_RQ_HDR) || (st == S_RQ_GLO) || (st == S_RQ_GHI);
    rd_addr = cur_q;
    if (st == S_RQ_GLO) rd_addr = cur_q + ADDR_W'(8);
    if (st == S_RQ_GHI) rd_addr = cur_q + ADDR_W'(16);
  end

  assign hdr_we  = hdr_in && !tbl_full;
  assign hdr_idx = cnt[AW-1:0];
  assign hdr_off = cur_q - base_q;
  assign glo_we  = (st == S_WT_GLO) && rd_valid;
  assign ghi_we  = (st == S_WT_GHI) && rd_valid;
  assign g_idx   = slot_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st     <= S_IDLE;
      cur_q  <= '0;
      base_q <= '0;
      cnt    <= '0;
      busy   <= 1'b0;
      done   <= 1'b0;
      err    <= WERR_NONE;
      last_q <= 1'b0;
      nxt_q  <= '0;
      slot_q <= '0;
    end else begin
      unique case (st)
        S_IDLE: if (start) begin
          base_q <= base_addr;
          cur_q  <= base_addr;
          cnt    <= '0;
          busy   <= 1'b1;
          done   <= 1'b0;
          err    <= WERR_NONE;
          st     <= S_RQ_HDR;
        end
        S_RQ_HDR: st <= S_WT_HDR;
        S_WT_HDR: if (rd_valid) begin
          if (tbl_full) begin
            busy <= 1'b0;
            done <= 1'b1;
            err  <= WERR_OVERFLOW;
            st   <= S_IDLE;
          end else begin
            slot_q <= cnt[AW-1:0];
            cnt    <= cnt + CW'(1);
            last_q <= in_last;
            nxt_q  <= in_nxt;
            st     <= guid_need ? S_RQ_GLO : S_HOP;
          end
        end
        S_RQ_GLO: st <= S_WT_GLO;
        S_WT_GLO: if (rd_valid) st <= S_RQ_GHI;
        S_RQ_GHI: st <= S_WT_GHI;
        S_WT_GHI: if (rd_valid) st <= S_HOP;
        S_HOP: begin
          if (walk_stop) begin
            busy <= 1'b0;
            done <= 1'b1;
            err  <= last_q ? WERR_NONE : hop_err;
            st   <= S_IDLE;
          end else begin
            cur_q <= cur_q + ADDR_W'(nxt_q);
            st    <= S_RQ_HDR;
          end
        end
        default: st <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/fcw_walker.sv
module fcw_walker
  import fcw_pkg::*;
#(
  parameter int DEPTH  = 8,
  parameter int ADDR_W = 32,
  localparam int AW    = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CW    = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [ADDR_W-1:0] base_addr,
  output logic              rd_req,
  output logic [ADDR_W-1:0] rd_addr,
  input  logic              rd_valid,
  input  logic [63:0]       rd_data,
  output logic              busy,
  output logic              done,
  output logic [1:0]        err_code,
  output logic [CW-1:0]     tbl_count,
  input  logic [AW-1:0]     tbl_idx,
  output logic [3:0]        tbl_kind,
  output logic [11:0]       tbl_fid,
  output logic [3:0]        tbl_rev,
  output logic [ADDR_W-1:0] tbl_offset,
  output logic [127:0]      tbl_guid
);
  hdr_t              fields;
  logic              guid_need;
  walk_err_e         err;
  logic              hdr_we, glo_we, ghi_we;
  logic [AW-1:0]     hdr_idx, g_idx;
  logic [ADDR_W-1:0] hdr_off;

  fcw_hdr_decode u_dec (
    .word      (rd_data),
    .fields    (fields),
    .guid_need (guid_need)
  );

  fcw_walk_ctrl #(.DEPTH(DEPTH), .ADDR_W(ADDR_W), .AW(AW), .CW(CW)) u_ctrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (start),
    .base_addr (base_addr),
    .rd_valid  (rd_valid),
    .in_last   (fields.last),
    .in_nxt    (fields.nxt),
    .guid_need (guid_need),
    .rd_req    (rd_req),
    .rd_addr   (rd_addr),
    .busy      (busy),
    .done      (done),
    .err       (err),
    .cnt       (tbl_count),
    .hdr_we    (hdr_we),
    .hdr_idx   (hdr_idx),
    .hdr_off   (hdr_off),
    .glo_we    (glo_we),
    .ghi_we    (ghi_we),
    .g_idx     (g_idx)
  );

  fcw_table #(.DEPTH(DEPTH), .ADDR_W(ADDR_W), .AW(AW)) u_tbl (
    .clk      (clk),
    .rst_n    (rst_n),
    .hdr_we   (hdr_we),
    .hdr_idx  (hdr_idx),
    .hdr_kind (fields.kind),
    .hdr_fid  (fields.fid),
    .hdr_rev  (fields.rev),
    .hdr_off  (hdr_off),
    .glo_we   (glo_we),
    .ghi_we   (ghi_we),
    .g_idx    (g_idx),
    .g_data   (rd_data),
    .rd_idx   (tbl_idx),
    .rd_kind  (tbl_kind),
    .rd_fid   (tbl_fid),
    .rd_rev   (tbl_rev),
    .rd_off   (tbl_offset),
    .rd_guid  (tbl_guid)
  );

  assign err_code = err;
endmodule

// File: rtl/fcw_walker_chk.sv
module fcw_walker_chk #(
  parameter int DEPTH = 8,
  parameter int CW    = 4
) (
  input logic          clk,
  input logic          rst_n,
  input logic          start,
  input logic          rd_req,
  input logic          rd_valid,
  input logic          busy,
  input logic          done,
  input logic [1:0]    err_code,
  input logic [CW-1:0] tbl_count
);
  logic pend;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        pend <= 1'b0;
    else if (rd_req)   pend <= 1'b1;
    else if (rd_valid) pend <= 1'b0;
  end

  assert_req_single_R3: assert property (@(posedge clk) disable iff (!rst_n)
    rd_req |=> !rd_req);
  assert_one_outstanding_R3: assert property (@(posedge clk) disable iff (!rst_n)
    rd_req |-> !pend);
  assert_req_in_walk_R10: assert property (@(posedge clk) disable iff (!rst_n)
    rd_req |-> busy);
  assert_busy_done_excl_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !(busy && done));
  assert_done_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !start) |=> done);
  assert_err_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> (err_code == 2'd0));
  assert_no_overflow_R9: assert property (@(posedge clk) disable iff (!rst_n)
    tbl_count <= CW'(DEPTH));
endmodule

bind fcw_walker fcw_walker_chk #(.DEPTH(DEPTH), .CW(CW)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .start     (start),
  .rd_req    (rd_req),
  .rd_valid  (rd_valid),
  .busy      (busy),
  .done      (done),
  .err_code  (err_code),
  .tbl_count (tbl_count)
);

// File: tb/sim_fcw_walker.sv
module sim_fcw_walker;
  localparam int CLK_NS = 10;
  localparam int DEPTH  = 8;
  localparam int ADDR_W = 32;
  localparam int AW     = 3;
  localparam int CW     = 4;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              start = 1'b0;
  logic [ADDR_W-1:0] base_addr = '0;
  logic              rd_valid = 1'b0;
  logic [63:0]       rd_data = '0;
  logic [AW-1:0]     tbl_idx = '0;
  logic              rd_req, busy, done;
  logic [ADDR_W-1:0] rd_addr, tbl_offset;
  logic [1:0]        err_code;
  logic [CW-1:0]     tbl_count;
  logic [3:0]        tbl_kind, tbl_rev;
  logic [11:0]       tbl_fid;
  logic [127:0]      tbl_guid;

  fcw_walker #(.DEPTH(DEPTH), .ADDR_W(ADDR_W)) u0 (.*);

  always #(CLK_NS/2) clk = ~clk;

  int n_cmp = 0, n_bad = 0, cyc = 0;
  logic [63:0] mem [int];
  int exp_rd [$];
  int pend = 0, pend_cnt = 0, pend_addr = 0, lat_sel = 0;

  int         e_n;
  logic [1:0] e_err;
  logic [3:0] e_kind [DEPTH];
  logic [11:0] e_fid [DEPTH];
  logic [3:0] e_rev [DEPTH];
  int         e_off [DEPTH];
  logic [127:0] e_guid [DEPTH];

  function automatic logic [63:0] rdmem(int a);
    if (mem.exists(a)) return mem[a];
    return 64'd0;
  endfunction

  function automatic logic [63:0] mkhdr(logic [3:0] k, logic last, int nxt,
                                        logic [3:0] rev, logic [11:0] fid);
    logic [23:0] n24 = nxt[23:0];
    return {k, 8'h01, 11'h0, last, n24, rev, fid};
  endfunction

  task automatic chk(string req, string what, logic [127:0] act, logic [127:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // Memory responder and per-clock comparison against the expected read stream.
  always @(negedge clk) begin
    int was_pend;
    if (rst_n) begin
      chk("R10", "busy&done", {127'd0, busy && done}, 128'd0);
      was_pend = pend;
      rd_valid = 1'b0;
      if (pend != 0) begin
        pend_cnt--;
        if (pend_cnt == 0) begin
          rd_valid = 1'b1;
          rd_data  = rdmem(pend_addr);
          pend     = 0;
        end
      end
      if (rd_req) begin
        chk("R3", "request while pending", 128'(was_pend), 128'd0);
        if (exp_rd.size() == 0) begin
          chk("R6", "unexpected read addr", 128'(rd_addr), 128'hFFFF_FFFF);
        end else begin
          chk("R4", "read addr", 128'(rd_addr), 128'(exp_rd.pop_front()));
        end
        pend      = 1;
        pend_addr = int'(rd_addr);
        lat_sel++;
        pend_cnt  = 1 + (lat_sel % 3);
      end
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog: run did not finish, actual=hung expected=done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  // Behavioural reference: walk the memory image.
  task automatic model_walk(int base);
    int a = base;
    exp_rd.delete();
    e_n = 0;
    forever begin
      logic [63:0] w;
      int nx;
      exp_rd.push_back(a);
      w = rdmem(a);
      if (e_n == DEPTH) begin e_err = 2'd3; break; end
      e_kind[e_n] = w[63:60];
      e_fid[e_n]  = w[11:0];
      e_rev[e_n]  = w[15:12];
      e_off[e_n]  = a - base;
      e_guid[e_n] = '0;
      if (w[63:60] == 4'h1 || w[63:60] == 4'h4) begin
        exp_rd.push_back(a + 8);
        exp_rd.push_back(a + 16);
        e_guid[e_n] = {rdmem(a + 16), rdmem(a + 8)};
      end
      e_n++;
      nx = int'(w[39:16]);
      if (w[40])        begin e_err = 2'd0; break; end
      if (nx % 8 != 0)  begin e_err = 2'd1; break; end
      if (nx == 0)      begin e_err = 2'd2; break; end
      a = a + nx;
    end
  endtask

  task automatic run_walk(string tag, string rq, int base, int dist_base);
    int guard = 0;
    model_walk(base);
    @(negedge clk);
    base_addr = ADDR_W'(base);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    chk("R10", {tag, " busy after start"}, {127'd0, busy}, 128'd1);
    if (dist_base >= 0) begin
      repeat (3) @(negedge clk);
      base_addr = ADDR_W'(dist_base);
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
    end
    while (!done && guard < 5000) begin @(negedge clk); guard++; end
    chk(rq, {tag, " err_code"}, 128'(err_code), 128'(e_err));
    chk(rq, {tag, " count"}, 128'(tbl_count), 128'(e_n));
    chk("R6", {tag, " reads left"}, 128'(exp_rd.size()), 128'd0);
    for (int i = 0; i < e_n; i++) begin
      tbl_idx = AW'(i);
      #1;
      chk("R2", {tag, " kind"}, 128'(tbl_kind), 128'(e_kind[i]));
      chk("R2", {tag, " fid"},  128'(tbl_fid),  128'(e_fid[i]));
      chk("R2", {tag, " rev"},  128'(tbl_rev),  128'(e_rev[i]));
      chk("R2", {tag, " offset"}, 128'(tbl_offset), 128'(e_off[i]));
      chk("R5", {tag, " guid"}, tbl_guid, e_guid[i]);
    end
    repeat (4) @(negedge clk);
    chk("R10", {tag, " done held"}, {127'd0, done}, 128'd1);
  endtask

  initial begin
    // Chain A: private, accelerator with id, private ending (size field not followed).
    mem[32'h1000] = mkhdr(4'h3, 1'b0, 'h40, 4'h2, 12'h011);
    mem[32'h1040] = mkhdr(4'h1, 1'b0, 'h100, 4'h1, 12'h000);
    mem[32'h1048] = 64'h0123_4567_89AB_CDEF;
    mem[32'h1050] = 64'hFEDC_BA98_7654_3210;
    mem[32'h1140] = mkhdr(4'h3, 1'b1, 'h2000, 4'h5, 12'h0AB);
    mem[32'h3140] = mkhdr(4'h3, 1'b1, 'h8, 4'h0, 12'h777);
    // Misaligned hop.
    mem[32'h4000] = mkhdr(4'h3, 1'b0, 'h20, 4'h1, 12'h101);
    mem[32'h4020] = mkhdr(4'h2, 1'b0, 'h44, 4'h3, 12'h102);
    // Zero-distance management header.
    mem[32'h5000] = mkhdr(4'h4, 1'b0, 0, 4'h7, 12'h000);
    mem[32'h5008] = 64'hAAAA_5555_0000_1111;
    mem[32'h5010] = 64'h2222_3333_4444_BBBB;
    // Ten headers with no end: overflow.
    for (int i = 0; i < 10; i++)
      mem[32'h6000 + 'h18 * i] = mkhdr(4'h3, 1'b0, 'h18, 4'(i), 12'(i + 'h20));
    // Exactly DEPTH headers ending with the end flag.
    for (int i = 0; i < DEPTH; i++)
      mem[32'h7000 + 'h10 * i] = mkhdr(4'h2, (i == DEPTH - 1), 'h10, 4'(i), 12'(i + 'h40));
    // End flag with a misaligned size field, accelerator kind.
    mem[32'h8000] = mkhdr(4'h1, 1'b1, 'h13, 4'h9, 12'h0);
    mem[32'h8008] = 64'h1111_2222_3333_4444;
    mem[32'h8010] = 64'h5555_6666_7777_8888;

    #(CLK_NS * 3);
    @(negedge clk);
    chk("R1", "busy", {127'd0, busy}, 128'd0);
    chk("R1", "done", {127'd0, done}, 128'd0);
    chk("R1", "rd_req", {127'd0, rd_req}, 128'd0);
    chk("R1", "err_code", 128'(err_code), 128'd0);
    chk("R1", "count", 128'(tbl_count), 128'd0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    run_walk("chainA", "R6", 'h1000, -1);
    run_walk("misalign", "R7", 'h4000, -1);
    run_walk("zeroloop", "R8", 'h5000, -1);
    run_walk("overflow", "R9", 'h6000, -1);
    run_walk("exactfull", "R9", 'h7000, -1);
    run_walk("endmisal", "R6", 'h8000, -1);
    run_walk("restartA", "R11", 'h1000, 'h5000);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule